// File: doc/BRIEF.md
# USB Suspend and Wake-up Detector

This block watches the line state of a low-speed USB port, as reported by an external transceiver. The transceiver gives two signals: a differential receive bit that is high while the bus is in K-state, and a flag that is high while both lines sit at single-ended zero (SE0). The block brings both signals into its own clock domain. It shows them as a status byte and times how long the bus stays idle (J-state: no K and no SE0). When the idle time exceeds a threshold derived from the clock frequency (3 ms by default), it requests suspend.

Once suspended, the first non-idle sample counts as an end-of-suspend event. The block then holds the wake-up under observation. If K-state persists, the wake-up is classed as a resume. If SE0 persists, it is classed as a bus reset. If the line drops back to idle first, or no decision comes within a fixed window, it is classed as noise and the block stays suspended. A bus reset seen at any time restarts the suspend timer.

Software can force suspend with a control input. While forced, the idle timer stays blocked until a resume sequence completes or a bus reset occurs. Every detection comes out as a single-cycle pulse, meant to feed an interrupt register.

Top module: `usb_suspend_monitor`

## Requirements
- R1: `line_status` bit 2 shows the synchronized SE0 flag and bit 1 shows the synchronized K-state bit. Bit 0 and bits 7..3 always read 0. An input change appears after two clock edges.
- R2: In the running state, `susp_pulse` rises for one cycle after more than `CLK_KHZ*SUSP_MS` consecutive idle samples (idle means `rx_k`=0 and `rx_se0`=0). The pulse appears on the clock edge numbered limit+3, counting the first edge after the line turns idle as edge 1. A line that stays idle for exactly the limit gives no pulse, and any K or SE0 sample restarts the count.
- R3: After a suspend request, `suspended` is 1 and no further `susp_pulse` occurs, however long the bus stays idle, until the block returns to the running state.
- R4: While suspended, the first non-idle sample gives one `esusp_pulse`. `suspended` stays 1 while the wake-up is being classified.
- R5: K-state held for `K_MIN` consecutive samples after a wake-up gives `wake_valid` with `wake_class`=01 (resume) and clears `suspended`. The block re-enters the running state, with the idle timer armed, at the first idle sample after that.
- R6: SE0 held for `RST_CYC` consecutive samples, in any state, gives exactly one `reset_pulse` per SE0 episode. It puts the block in the running state with `suspended`=0. If a wake-up was being classified, it also gives `wake_valid` with `wake_class`=10 (reset).
- R7: A wake-up where the line returns to idle before either condition is met gives `wake_valid` with `wake_class`=11 (noise). `suspended` stays 1 and no `reset_pulse` is produced.
- R8: A wake-up that stays non-idle but reaches no decision within `WAKE_WIN` cycles (for example, K and SE0 alternating) is classed as noise (11), and the block returns to suspend.
- R9: A rising edge of `force_susp` in the running state sets `suspended` without a `susp_pulse`. The idle timer stays blocked until a resume completes or a bus reset occurs.
- R10: SE0 lasting `RST_CYC`-1 samples or fewer produces no `reset_pulse`.
- R11: While `rst_n` is low, every output is 0 and the block starts in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_k | input | 1 | Differential receiver output, 1 = K-state (asynchronous) |
| rx_se0 | input | 1 | Single-ended-zero flag (asynchronous) |
| force_susp | input | 1 | Software forced-suspend control; a rising edge takes effect |
| line_status | output | 8 | Live line status: bit 2 SE0, bit 1 K-state, other bits 0 |
| suspended | output | 1 | 1 while suspended or while a wake-up is being classified |
| susp_pulse | output | 1 | One-cycle suspend request |
| esusp_pulse | output | 1 | One-cycle end-of-suspend event |
| reset_pulse | output | 1 | One-cycle bus reset detection |
| wake_valid | output | 1 | One-cycle strobe: `wake_class` has been updated |
| wake_class | output | 2 | Last wake-up class: 01 resume, 10 reset, 11 noise, 00 none yet |

## Verification
The assertions take for granted two things about the inputs. First, the transceiver never reports K-state and SE0 in the same sample. Second, `force_susp` is synchronous to `clk`. Under those conditions every classification strobe carries a non-zero class, and a reset pulse always lands in the running state. The bench keeps to these limits. It drives the line with exactly one of J, K or SE0 at a time, and it changes every input on the falling clock edge. The random runs pick idle lengths and glitch lengths around the threshold, and they keep every glitch shorter than the reset length. That way the expected number of suspend requests depends only on the final idle run.

// File: rtl/usbsd_pkg.sv
package usbsd_pkg;

   // Link state of the suspend logic
   typedef enum logic [1:0] {
      ST_RUN    = 2'b00,
      ST_SUSP   = 2'b01,
      ST_WAKE   = 2'b10,
      ST_RESUME = 2'b11
   } susp_state_e;

   // Classification of a wake-up; the codes appear on the wake_class port
   typedef enum logic [1:0] {
      WK_NONE   = 2'b00,
      WK_RESUME = 2'b01,
      WK_RESET  = 2'b10,
      WK_NOISE  = 2'b11
   } wake_kind_e;

endpackage

// File: rtl/usbsd_sync.sv
module usbsd_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("usbsd_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("usbsd_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/usbsd_idle_timer.sv
module usbsd_idle_timer #(
   parameter int LIMIT = 144000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic idle,
   output logic hit
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("usbsd_idle_timer: LIMIT must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!en || !idle)   cnt <= '0;
      else if (cnt != LIM_V)   cnt <= cnt + 1'b1;
   end

   // one sample beyond LIMIT idle samples
   assign hit = en && idle && (cnt == LIM_V);

   // R2
   idle_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($past(idle) && $past(en)));

endmodule

// File: rtl/usbsd_se0_det.sv
module usbsd_se0_det #(
   parameter int RST_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic se0,
   output logic hit
);

   generate
      if (RST_CYC < 2) begin : g_bad_rst
         $error("usbsd_se0_det: RST_CYC must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(RST_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(RST_CYC);
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= '0;
      else if (!se0)         run <= '0;
      else if (run != FULL)  run <= run + 1'b1;
   end

   // fires once, on the RST_CYC-th consecutive SE0 sample
   assign hit = se0 && (run == LAST);

   // R10
   rst_needs_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(se0));

endmodule

// File: rtl/usbsd_wake_fsm.sv
module usbsd_wake_fsm
   import usbsd_pkg::*;
#(
   parameter int K_MIN    = 6,
   parameter int WAKE_WIN = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        k,
   input  logic        se0,
   input  logic        susp_hit,
   input  logic        force_rise,
   input  logic        bus_rst,
   output susp_state_e state,
   output logic        esusp_ev,
   output logic        wake_ev,
   output wake_kind_e  wake_kind
);

   generate
      if (K_MIN < 2) begin : g_bad_kmin
         $error("usbsd_wake_fsm: K_MIN must be at least 2");
      end
      if (WAKE_WIN <= K_MIN) begin : g_bad_win
         $error("usbsd_wake_fsm: WAKE_WIN must exceed K_MIN");
      end
   endgenerate

   localparam int KW = $clog2(K_MIN + 1);
   localparam int WW = $clog2(WAKE_WIN + 1);
   localparam logic [KW-1:0] KLAST = KW'(K_MIN - 1);
   localparam logic [WW-1:0] WLAST = WW'(WAKE_WIN - 1);

   susp_state_e   nxt;
   logic [KW-1:0] krun;
   logic [WW-1:0] win;
   logic          idle;

   assign idle = !k && !se0;

   always_comb begin
      nxt       = state;
      esusp_ev  = 1'b0;
      wake_ev   = 1'b0;
      wake_kind = WK_NONE;
      if (bus_rst) begin
         nxt = ST_RUN;
         if (state == ST_WAKE) begin
            wake_ev   = 1'b1;
            wake_kind = WK_RESET;
         end
      end else begin
         unique case (state)
            ST_RUN: begin
               if (susp_hit || force_rise) nxt = ST_SUSP;
            end
            ST_SUSP: begin
               if (!idle) begin
                  nxt      = ST_WAKE;
                  esusp_ev = 1'b1;
               end
            end
            ST_WAKE: begin
               if (idle) begin
                  nxt       = ST_SUSP;
                  wake_ev   = 1'b1;
                  wake_kind = WK_NOISE;
               end else if (k && (krun == KLAST)) begin
                  nxt       = ST_RESUME;
                  wake_ev   = 1'b1;
                  wake_kind = WK_RESUME;
               end else if (win == WLAST) begin
                  nxt       = ST_SUSP;
                  wake_ev   = 1'b1;
                  wake_kind = WK_NOISE;
               end
            end
            ST_RESUME: begin
               if (idle) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         krun  <= '0;
         win   <= '0;
      end else begin
         state <= nxt;
         if (state == ST_SUSP) begin
            krun <= k ? KW'(1) : '0;
            win  <= '0;
         end else if (state == ST_WAKE) begin
            krun <= k ? krun + 1'b1 : '0;
            win  <= win + 1'b1;
         end else begin
            krun <= '0;
            win  <= '0;
         end
      end
   end

   // R5
   resume_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WAKE && state == ST_RESUME) |-> $past(k));

   // R8
   wake_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |-> (win < WW'(WAKE_WIN)));

endmodule

// File: rtl/usb_suspend_monitor.sv
module usb_suspend_monitor
   import usbsd_pkg::*;
#(
   parameter int CLK_KHZ     = 48000,
   parameter int SUSP_MS     = 3,
   parameter int RST_CYC     = 8,
   parameter int K_MIN       = 6,
   parameter int WAKE_WIN    = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_k,
   input  logic       rx_se0,
   input  logic       force_susp,
   output logic [7:0] line_status,
   output logic       suspended,
   output logic       susp_pulse,
   output logic       esusp_pulse,
   output logic       reset_pulse,
   output logic       wake_valid,
   output logic [1:0] wake_class
);

   generate
      if (CLK_KHZ < 1 || SUSP_MS < 1) begin : g_bad_time
         $error("usb_suspend_monitor: CLK_KHZ and SUSP_MS must be positive");
      end
   endgenerate

   localparam int IDLE_LIMIT = CLK_KHZ * SUSP_MS;

   logic [1:0]  line_s;
   logic        k_s, se0_s, idle_s;
   logic        force_d, force_rise;
   logic        susp_hit, bus_rst;
   logic        esusp_ev, wake_ev;
   wake_kind_e  wake_kind;
   susp_state_e state;

   logic        susp_q, esusp_q, rst_q, wake_q;
   logic [1:0]  class_q;

   usbsd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_k, rx_se0}),
      .q     (line_s)
   );

   assign k_s    = line_s[1];
   assign se0_s  = line_s[0];
   assign idle_s = !k_s && !se0_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) force_d <= 1'b0;
      else        force_d <= force_susp;
   end
   assign force_rise = force_susp && !force_d;

   usbsd_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state == ST_RUN),
      .idle  (idle_s),
      .hit   (susp_hit)
   );

   usbsd_se0_det #(.RST_CYC(RST_CYC)) u_se0 (
      .clk   (clk),
      .rst_n (rst_n),
      .se0   (se0_s),
      .hit   (bus_rst)
   );

   usbsd_wake_fsm #(.K_MIN(K_MIN), .WAKE_WIN(WAKE_WIN)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .k          (k_s),
      .se0        (se0_s),
      .susp_hit   (susp_hit),
      .force_rise (force_rise),
      .bus_rst    (bus_rst),
      .state      (state),
      .esusp_ev   (esusp_ev),
      .wake_ev    (wake_ev),
      .wake_kind  (wake_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q  <= 1'b0;
         esusp_q <= 1'b0;
         rst_q   <= 1'b0;
         wake_q  <= 1'b0;
         class_q <= WK_NONE;
      end else begin
         susp_q  <= susp_hit;
         esusp_q <= esusp_ev;
         rst_q   <= bus_rst;
         wake_q  <= wake_ev;
         if (wake_ev) class_q <= wake_kind;
      end
   end

   assign line_status = {5'b0, se0_s, k_s, 1'b0};
   assign suspended   = (state == ST_SUSP) || (state == ST_WAKE);
   assign susp_pulse  = susp_q;
   assign esusp_pulse = esusp_q;
   assign reset_pulse = rst_q;
   assign wake_valid  = wake_q;
   assign wake_class  = class_q;

   // R2
   susp_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_pulse |-> suspended);

   // R3
   susp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_pulse |=> !susp_pulse);

   // R4
   esusp_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esusp_pulse |-> ($past(suspended) && suspended));

   // R4
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({susp_pulse, esusp_pulse}));

   // R6
   rst_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> !suspended);

   // R7
   wake_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (wake_class != 2'b00));

endmodule

// File: tb/usb_suspend_monitor_bench.sv
`timescale 1ns/1ps
module usb_suspend_monitor_bench;

   localparam int CLK_KHZ  = 100;
   localparam int SUSP_MS  = 3;
   localparam int LIMIT    = CLK_KHZ * SUSP_MS;
   localparam int RST_CYC  = 8;
   localparam int K_MIN    = 6;
   localparam int WAKE_WIN = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_k = 1'b1;
   logic       rx_se0 = 1'b0;
   logic       force_susp = 1'b0;
   logic [7:0] line_status;
   logic       suspended, susp_pulse, esusp_pulse, reset_pulse, wake_valid;
   logic [1:0] wake_class;

   usb_suspend_monitor #(
      .CLK_KHZ(CLK_KHZ), .SUSP_MS(SUSP_MS), .RST_CYC(RST_CYC),
      .K_MIN(K_MIN), .WAKE_WIN(WAKE_WIN), .SYNC_STAGES(2)
   ) u_usb_suspend_monitor (
      .clk(clk), .rst_n(rst_n), .rx_k(rx_k), .rx_se0(rx_se0),
      .force_susp(force_susp), .line_status(line_status),
      .suspended(suspended), .susp_pulse(susp_pulse),
      .esusp_pulse(esusp_pulse), .reset_pulse(reset_pulse),
      .wake_valid(wake_valid), .wake_class(wake_class)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   int n_chk = 0, n_err = 0;
   int n_susp = 0, n_esusp = 0, n_rst = 0, n_wake = 0;
   int last_cls = 0, susp_at = 0;
   int s_susp, s_esusp, s_rst, s_wake, c0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (susp_pulse)  begin n_susp++; susp_at = cyc; end
         if (esusp_pulse) n_esusp++;
         if (reset_pulse) n_rst++;
         if (wake_valid)  begin n_wake++; last_cls = int'(wake_class); end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic k, input logic s, input int n);
      rx_k = k;
      rx_se0 = s;
      repeat (n) @(negedge clk);
   endtask

   task automatic snap();
      s_susp = n_susp; s_esusp = n_esusp; s_rst = n_rst; s_wake = n_wake;
   endtask

   task automatic to_run();
      drive(1'b0, 1'b1, RST_CYC + 3);
      drive(1'b1, 1'b0, 4);
   endtask

   // expected suspend requests for a final idle run of l samples
   function automatic int exp_susp(input int l);
      return (l > LIMIT) ? 1 : 0;
   endfunction

   initial begin
      #1_500_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 line_status", int'(line_status), 0);
      chk("R11 suspended", int'(suspended), 0);
      chk("R11 pulses", int'({susp_pulse, esusp_pulse, reset_pulse, wake_valid}), 0);
      chk("R11 wake_class", int'(wake_class), 0);
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 4);
      chk("R1 K status", int'(line_status), 8'h02);

      // R1 / R10: short SE0 visible, no reset
      snap();
      drive(1'b0, 1'b1, 3);
      chk("R1 SE0 status", int'(line_status), 8'h04);
      drive(1'b0, 1'b1, RST_CYC - 4);
      drive(1'b1, 1'b0, 6);
      chk("R10 short SE0 no reset", n_rst - s_rst, 0);

      // R6 exact-length SE0 in run: one reset pulse
      snap();
      drive(1'b0, 1'b1, RST_CYC);
      drive(1'b1, 1'b0, 6);
      chk("R6 reset in run", n_rst - s_rst, 1);
      chk("R6 no wake in run", n_wake - s_wake, 0);
      chk("R6 running", int'(suspended), 0);
      snap();
      drive(1'b0, 1'b1, 5 * RST_CYC);
      drive(1'b1, 1'b0, 6);
      chk("R6 one pulse per episode", n_rst - s_rst, 1);

      // R2 boundary: exactly LIMIT idle samples -> none
      snap();
      drive(1'b0, 1'b0, LIMIT);
      drive(1'b1, 1'b0, 3);
      chk("R2 idle equal to limit", n_susp - s_susp, 0);
      drive(1'b1, 1'b0, 5);

      // R2 exact latency
      snap();
      c0 = cyc;
      drive(1'b0, 1'b0, LIMIT + 10);
      chk("R2 suspend count", n_susp - s_susp, 1);
      chk("R2 latency", susp_at - c0, LIMIT + 3);
      chk("R3 suspended", int'(suspended), 1);
      snap();
      drive(1'b0, 1'b0, 2 * LIMIT + 5);
      chk("R3 no repeat", n_susp - s_susp, 0);

      // R7 SE0 glitch noise
      snap();
      drive(1'b0, 1'b1, RST_CYC - 4);
      drive(1'b0, 1'b0, 10);
      chk("R4 end of suspend", n_esusp - s_esusp, 1);
      chk("R7 SE0 glitch class", last_cls, 3);
      chk("R7 wake count", n_wake - s_wake, 1);
      chk("R7 no reset", n_rst - s_rst, 0);
      chk("R7 still suspended", int'(suspended), 1);

      // R7 K glitch noise
      snap();
      drive(1'b1, 1'b0, K_MIN - 3);
      drive(1'b0, 1'b0, 10);
      chk("R7 K glitch class", last_cls, 3);
      chk("R7 K glitch suspended", int'(suspended), 1);

      // R8 alternating K and SE0 never decides
      snap();
      for (int i = 0; i < (WAKE_WIN + 8) / 4; i++) begin
         drive(1'b1, 1'b0, 2);
         drive(1'b0, 1'b1, 2);
      end
      drive(1'b0, 1'b0, 10);
      chk("R8 window noise class", last_cls, 3);
      chk("R8 window wake seen", (n_wake - s_wake) >= 1 ? 1 : 0, 1);
      chk("R8 no reset", n_rst - s_rst, 0);
      chk("R8 suspended", int'(suspended), 1);

      // R5 resume then timer re-armed
      snap();
      drive(1'b1, 1'b0, K_MIN + 5);
      chk("R5 resume class", last_cls, 1);
      chk("R5 resume clears suspended", int'(suspended), 0);
      chk("R4 esusp on resume", n_esusp - s_esusp, 1);
      drive(1'b0, 1'b1, 2);
      snap();
      drive(1'b0, 1'b0, LIMIT + 10);
      chk("R5 timer rearmed after resume", n_susp - s_susp, 1);

      // R6 reset while classifying a wake-up
      snap();
      drive(1'b0, 1'b1, RST_CYC + 5);
      chk("R6 wake reset class", last_cls, 2);
      chk("R6 wake reset pulse", n_rst - s_rst, 1);
      chk("R6 wake reset running", int'(suspended), 0);
      drive(1'b1, 1'b0, 4);

      // R9 forced suspend
      snap();
      drive(1'b0, 1'b0, 2);
      force_susp = 1'b1;
      drive(1'b0, 1'b0, 4);
      chk("R9 forced suspended", int'(suspended), 1);
      chk("R9 no suspend pulse", n_susp - s_susp, 0);
      drive(1'b0, 1'b0, 2 * LIMIT + 5);
      chk("R9 timer blocked", n_susp - s_susp, 0);
      force_susp = 1'b0;
      drive(1'b1, 1'b0, K_MIN + 3);
      chk("R9 resume ends force", int'(suspended), 0);
      drive(1'b0, 1'b1, 2);
      snap();
      drive(1'b0, 1'b0, LIMIT + 10);
      chk("R9 timer after resume", n_susp - s_susp, 1);
      to_run();
      drive(1'b0, 1'b0, 2);
      force_susp = 1'b1;
      drive(1'b0, 1'b0, 4);
      force_susp = 1'b0;
      to_run();
      chk("R9 bus reset ends force", int'(suspended), 0);

      // R2 random: sub-limit idle, glitch, idle near limit
      for (int it = 0; it < 16; it++) begin
         int l1, g, l2;
         logic gk;
         l1 = 1 + int'($urandom % LIMIT);
         g  = 1 + int'($urandom % 3);
         gk = logic'($urandom % 2);
         l2 = LIMIT - 20 + int'($urandom % 41);
         snap();
         drive(1'b0, 1'b0, l1);
         drive(gk, ~gk, g);
         drive(1'b0, 1'b0, l2);
         drive(1'b1, 1'b0, 8);
         chk("R2 random idle", n_susp - s_susp, exp_susp(l2));
         to_run();
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule